// File: doc/BRIEF.md
# Timer Channel Capture/Compare/PWM Unit

This block is one channel of a shared up-counting timer. It watches the timer's counter value and a per-cycle step strobe, and it either time-stamps edges on its pin (input capture), acts on the pin when the counter reaches the channel value (output compare), or shapes a pulse train from that value (edge-aligned or center-aligned PWM). A small register bus reads and writes an 8-bit status/control byte and a counter-width value register. The channel drives its pin output, a pin output-enable and an interrupt request.

The channel event flag is cleared by a handshake that is managed by a three-state machine. The states are `FLG_IDLE` (no event pending), `FLG_SET` (event pending, clear not armed) and `FLG_ARMED` (event pending, a status read has armed the clear). The transitions are: IDLE→SET on an event; SET→ARMED on a status read; ARMED→IDLE on a status write with bit 7 = 0; ARMED→SET on an event, which cancels the clear. Any event also moves SET to SET. The pin level is held as a two-state machine, `LVL_LOW` and `LVL_HIGH`. It moves on compare matches and counter wraps as the mode and the edge/level code select.

Mode decode works as follows. When the global center select is 1, the channel is center-aligned PWM. Otherwise mode-select B = 1 gives edge-aligned PWM, and with mode-select B = 0, mode-select A = 0 gives input capture and 1 gives output compare.

Top module: `tmr_chan`

## Requirements
- R1: After reset the status/control byte reads 0, the value register reads 0, and the interrupt request, pin output and output-enable are all 0.
- R2: The status/control byte holds the event flag at bit 7, interrupt enable at bit 6, mode-select B at bit 5, mode-select A at bit 4, and the edge/level code at bits 3:2. Bits 1:0 and all bits above 7 read 0, and the flag is never set by a write.
- R3: In input capture, the pin passes through two synchronizer stages. Edge/level code 01 captures rising edges, 10 captures falling edges and 11 captures both. On the second clock edge after a new pin level is first sampled, the event flag sets and the counter value is latched into the value register. A capture has priority over a bus write to the value register in the same cycle.
- R4: In output compare, a match is a cycle in which the step strobe is 1 and the counter equals the value register. A match sets the flag and, one cycle later, changes the pin as the code selects: 01 toggles it, 10 drives it low, 11 drives it high.
- R5: In edge-aligned PWM a match sets the flag. With code 10 the pin goes high at a counter wrap (step with counter 0) and low at a match. With code 01 or 11 the levels are inverted. A match wins over a wrap in the same cycle.
- R6: In center-aligned PWM (global center select = 1) every match sets the flag and toggles the pin.
- R7: The interrupt request is 1 exactly while the flag and the interrupt enable are both 1.
- R8: The flag clears only on a status write with bit 7 = 0 that follows a status read made while the flag was set. A write without such a read, or a write with bit 7 = 1, leaves the flag set.
- R9: An event after the arming read and before the clearing write cancels the clear, and the flag stays set.
- R10: Edge/level code 00 drives the output-enable to 0 and freezes the pin level, while compare matches still set the flag.
- R11: While the step strobe is 0, a counter equal to the value register produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CW | Shared timer counter value |
| cnt_step_i | input | 1 | Counter shows a freshly advanced value this cycle |
| center_i | input | 1 | Global center-aligned PWM select |
| pin_i | input | 1 | Channel pin input (asynchronous) |
| bus_sel_i | input | 1 | Register select: 0 status/control byte, 1 value register |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | CW | Write data |
| bus_rdata_o | output | CW | Read data for the selected register |
| pin_o | output | 1 | Channel pin output level |
| pin_oe_o | output | 1 | Channel pin output-enable |
| irq_o | output | 1 | Channel interrupt request |

## Verification
The bench builds the channel with an 8-bit counter (CW = 8) and the default two-stage synchronizer. With this setting, counter wraps and value matches occur every 256 steps, so random runs of tens of thousands of cycles pass through every mode's match, wrap and match-at-wrap case many times. The short counter also lets random value writes hit and miss the counter often, and it lets bus reads and writes interleave with events. This exercises the cancelled-clear path of the flag handshake.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        MODE_CAP  = 2'd0,
        MODE_CMP  = 2'd1,
        MODE_EPWM = 2'd2,
        MODE_CPWM = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pin_lvl_e;

    // status/control byte bit positions (software decodes these)
    localparam int CTL_FLAG = 7;
    localparam int CTL_IE   = 6;
    localparam int CTL_MSB  = 5;
    localparam int CTL_MSA  = 4;
    localparam int CTL_EL_H = 3;
    localparam int CTL_EL_L = 2;

    function automatic chan_mode_e decode_mode(input logic center,
                                               input logic msb,
                                               input logic msa);
        if (center)   return MODE_CPWM;
        else if (msb) return MODE_EPWM;
        else if (msa) return MODE_CMP;
        else          return MODE_CAP;
    endfunction

endpackage

// File: rtl/tmr_chan_flag.sv
module tmr_chan_flag
    import tmr_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_ctl_i,
    input  logic wr_ctl_i,
    input  logic wr_flag_bit_i,
    output logic flag_o
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (evt_i) state_d = FLG_SET;
            end
            FLG_SET: begin
                if (evt_i)         state_d = FLG_SET;
                else if (rd_ctl_i) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (evt_i)                            state_d = FLG_SET;
                else if (wr_ctl_i && !wr_flag_bit_i)  state_d = FLG_IDLE;
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_comb flag_o = (state_q != FLG_IDLE);

    // R9
    evt_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> state_q == FLG_SET);

    // R8
    no_blind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET && !rd_ctl_i) |=> state_q != FLG_IDLE);

endmodule

// File: rtl/tmr_chan_capture.sv
module tmr_chan_capture #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       en_i,
    input  logic [1:0] edge_sel_i,
    output logic       cap_o
);

    localparam int LAST = SYNC;

    // sh[0..SYNC-1] synchronizer, sh[SYNC] previous synchronized level
    logic [LAST:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[LAST-1:0], pin_i};
    end

    logic now_lvl, old_lvl, rise, fall;

    always_comb begin
        now_lvl = sh_q[LAST-1];
        old_lvl = sh_q[LAST];
        rise    = now_lvl && !old_lvl;
        fall    = !now_lvl && old_lvl;
        cap_o   = 1'b0;
        if (en_i) begin
            unique case (edge_sel_i)
                2'b01:   cap_o = rise;
                2'b10:   cap_o = fall;
                2'b11:   cap_o = rise || fall;
                default: cap_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tmr_chan_out.sv
module tmr_chan_out
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_mode_e mode_i,
    input  logic [1:0] els_i,
    input  logic       match_i,
    input  logic       wrap_i,
    output logic       pin_o
);

    pin_lvl_e lvl_q, lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LOW;
        else        lvl_q <= lvl_d;
    end

    always_comb begin
        lvl_d = lvl_q;
        if (els_i != 2'b00) begin
            unique case (mode_i)
                MODE_CAP: lvl_d = lvl_q;
                MODE_CMP: begin
                    if (match_i) begin
                        unique case (els_i)
                            2'b01:   lvl_d = (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
                            2'b10:   lvl_d = LVL_LOW;
                            default: lvl_d = LVL_HIGH;
                        endcase
                    end
                end
                MODE_EPWM: begin
                    if (match_i)     lvl_d = els_i[0] ? LVL_HIGH : LVL_LOW;
                    else if (wrap_i) lvl_d = els_i[0] ? LVL_LOW  : LVL_HIGH;
                end
                MODE_CPWM: begin
                    if (match_i) lvl_d = (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
                end
                default: lvl_d = lvl_q;
            endcase
        end
    end

    always_comb pin_o = (lvl_q == LVL_HIGH);

    // R10
    released_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (els_i == 2'b00) |=> $stable(lvl_q));

    // R5
    epwm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_EPWM && els_i != 2'b00 && match_i)
            |=> pin_o == $past(els_i[0]));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CW   = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          cnt_step_i,
    input  logic          center_i,
    input  logic          pin_i,
    input  logic          bus_sel_i,
    input  logic          bus_rd_i,
    input  logic          bus_wr_i,
    input  logic [CW-1:0] bus_wdata_i,
    output logic [CW-1:0] bus_rdata_o,
    output logic          pin_o,
    output logic          pin_oe_o,
    output logic          irq_o
);

    localparam int CTL_W = 8;

    initial begin
        if (CW < CTL_W) $error("tmr_chan: CW must be at least %0d", CTL_W);
        if (SYNC < 1)   $error("tmr_chan: SYNC must be at least 1");
    end

    logic          ie_q, msb_q, msa_q;
    logic [1:0]    els_q;
    logic [CW-1:0] val_q;
    chan_mode_e    mode;
    logic          match, wrap, cap_evt, evt, flag;
    logic          wr_ctl, wr_val, rd_ctl;

    always_comb begin
        mode   = decode_mode(center_i, msb_q, msa_q);
        match  = cnt_step_i && (cnt_i == val_q);
        wrap   = cnt_step_i && (cnt_i == '0);
        evt    = (mode == MODE_CAP) ? cap_evt : match;
        wr_ctl = bus_wr_i && !bus_sel_i;
        wr_val = bus_wr_i && bus_sel_i;
        rd_ctl = bus_rd_i && !bus_sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            msb_q <= 1'b0;
            msa_q <= 1'b0;
            els_q <= 2'b00;
        end else if (wr_ctl) begin
            ie_q  <= bus_wdata_i[CTL_IE];
            msb_q <= bus_wdata_i[CTL_MSB];
            msa_q <= bus_wdata_i[CTL_MSA];
            els_q <= bus_wdata_i[CTL_EL_H:CTL_EL_L];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       val_q <= '0;
        else if (cap_evt) val_q <= cnt_i;
        else if (wr_val)  val_q <= bus_wdata_i;
    end

    tmr_chan_capture #(.SYNC(SYNC)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .en_i       (mode == MODE_CAP),
        .edge_sel_i (els_q),
        .cap_o      (cap_evt)
    );

    tmr_chan_flag u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_i         (evt),
        .rd_ctl_i      (rd_ctl),
        .wr_ctl_i      (wr_ctl),
        .wr_flag_bit_i (bus_wdata_i[CTL_FLAG]),
        .flag_o        (flag)
    );

    tmr_chan_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .els_i   (els_q),
        .match_i (match),
        .wrap_i  (wrap),
        .pin_o   (pin_o)
    );

    logic [CTL_W-1:0] ctl_byte;

    always_comb begin
        ctl_byte                     = '0;
        ctl_byte[CTL_FLAG]           = flag;
        ctl_byte[CTL_IE]             = ie_q;
        ctl_byte[CTL_MSB]            = msb_q;
        ctl_byte[CTL_MSA]            = msa_q;
        ctl_byte[CTL_EL_H:CTL_EL_L]  = els_q;
        bus_rdata_o                  = '0;
        if (bus_sel_i) bus_rdata_o = val_q;
        else           bus_rdata_o[CTL_W-1:0] = ctl_byte;
        pin_oe_o = (els_q != 2'b00);
        irq_o    = flag && ie_q;
    end

    // R3
    cap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> mode == MODE_CAP);

    // R3
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> val_q == $past(cnt_i));

    // R11
    no_step_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_step_i && mode != MODE_CAP && !rd_ctl && !wr_ctl) |=> $stable(flag));

endmodule

// File: tb/tmr_chan_bench.sv
module tmr_chan_bench;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic          step = 1'b0, center = 1'b0, pin = 1'b0;
    logic          sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          pin_o, pin_oe, irq;

    always #4 clk = ~clk;

    tmr_chan #(.CW(CW), .SYNC(2)) u_tmr_chan (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_step_i(step),
        .center_i(center), .pin_i(pin), .bus_sel_i(sel), .bus_rd_i(rd),
        .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pin_o(pin_o), .pin_oe_o(pin_oe), .irq_o(irq)
    );

    int checks = 0, errs = 0;
    bit free_run = 1'b0;

    // reference model (flag: 0 idle, 1 set, 2 armed)
    int            m_fs;
    logic          m_ie, m_msb, m_msa, m_out, s1, s2, s3;
    logic [1:0]    m_els;
    logic [CW-1:0] m_val;

    function automatic int f_mode(logic c, logic b, logic a);
        if (c) return 3;
        if (b) return 2;
        if (a) return 1;
        return 0;
    endfunction

    function automatic logic f_out(int md, logic [1:0] el, logic cur,
                                   logic mt, logic wp);
        if (el == 2'b00) return cur;
        case (md)
            1: if (mt) return (el == 2'b01) ? !cur : (el == 2'b11);
            2: begin
                if (mt) return el[0];
                if (wp) return !el[0];
            end
            3: if (mt) return !cur;
            default: return cur;
        endcase
        return cur;
    endfunction

    always @(posedge clk) begin
        int md;
        logic mt, wp, cp, ev;
        if (!rst_n) begin
            m_fs = 0; m_ie = 0; m_msb = 0; m_msa = 0; m_els = 0;
            m_val = 0; m_out = 0; s1 = 0; s2 = 0; s3 = 0;
        end else begin
            md = f_mode(center, m_msb, m_msa);
            mt = step && (cnt == m_val);
            wp = step && (cnt == 0);
            cp = (md == 0) && (s2 != s3) &&
                 ((m_els == 2'b01 && s2) || (m_els == 2'b10 && !s2) || m_els == 2'b11);
            ev = (md == 0) ? cp : mt;
            m_out = f_out(md, m_els, m_out, mt, wp);
            if (ev) m_fs = 1;
            else if (m_fs == 1 && rd && !sel) m_fs = 2;
            else if (m_fs == 2 && wr && !sel && !wdata[7]) m_fs = 0;
            if (cp) m_val = cnt;
            else if (wr && sel) m_val = wdata;
            if (wr && !sel) begin
                m_ie = wdata[6]; m_msb = wdata[5]; m_msa = wdata[4]; m_els = wdata[3:2];
            end
            s3 = s2; s2 = s1; s1 = pin;
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cmp_all();
        int md;
        md = f_mode(center, m_msb, m_msa);
        chk("R7 irq", irq, (m_fs != 0) && m_ie);
        chk("R10 oe", pin_oe, m_els != 2'b00);
        case (md)
            0: chk("R10 pin hold", pin_o, m_out);
            1: chk("R4 pin", pin_o, m_out);
            2: chk("R5 pin", pin_o, m_out);
            default: chk("R6 pin", pin_o, m_out);
        endcase
        if (sel) chk("R3 value", rdata, m_val);
        else     chk("R8 ctl", rdata, {m_fs != 0, m_ie, m_msb, m_msa, m_els, 2'b00});
    endtask

    task automatic tick();
        @(negedge clk);
        cmp_all();
        if (free_run) begin
            step = ($urandom % 8) != 0;
            if (step) cnt = cnt + 1'b1;
        end
    endtask

    task automatic bus_wr(logic s, logic [CW-1:0] d);
        sel = s; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic bus_rd(logic s);
        sel = s; rd = 1'b1;
        tick();
        rd = 1'b0;
    endtask

    task automatic rd_now(logic s, output logic [CW-1:0] v);
        sel = s;
        #1;
        v = rdata;
    endtask

    task automatic one_match(logic [CW-1:0] v);
        cnt = v; step = 1'b1;
        tick();
        step = 1'b0; cnt = v + 1'b1;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++; errs++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [CW-1:0] v;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd_now(0, v); chk("R1 ctl", v, 0);
        rd_now(1, v); chk("R1 value", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 oe", pin_oe, 0);
        chk("R1 pin", pin_o, 0);
        // R2 layout: flag not writable, low bits zero
        bus_wr(0, 8'hFF);
        rd_now(0, v); chk("R2 layout", v, 8'h7C);
        // output compare, set on match, interrupt enabled
        bus_wr(0, 8'h5C);
        bus_wr(1, 8'd40);
        cnt = 8'd40; step = 1'b0;
        repeat (4) tick();
        rd_now(0, v); chk("R11 no step no flag", v[7], 0);
        one_match(8'd40);
        tick();
        rd_now(0, v); chk("R4 flag", v[7], 1);
        chk("R7 irq", irq, 1);
        chk("R4 set action", pin_o, 1);
        // R8 write 0 without read leaves flag
        bus_wr(0, 8'h5C);
        rd_now(0, v); chk("R8 blind write", v[7], 1);
        bus_rd(0);
        bus_wr(0, 8'hDC);
        rd_now(0, v); chk("R8 write one", v[7], 1);
        bus_wr(0, 8'h5C);
        rd_now(0, v); chk("R8 clear", v[7], 0);
        chk("R7 irq low", irq, 0);
        // R9 event between read and write cancels clear
        one_match(8'd40);
        bus_rd(0);
        one_match(8'd40);
        bus_wr(0, 8'h5C);
        rd_now(0, v); chk("R9 cancel", v[7], 1);
        // R3 capture rising edge with code 01
        bus_wr(0, 8'h44);
        cnt = 8'd77;
        pin = 1'b1;
        repeat (3) tick();
        rd_now(1, v); chk("R3 rise capture", v, 77);
        cnt = 8'd90;
        pin = 1'b0;
        repeat (4) tick();
        rd_now(1, v); chk("R3 falling ignored", v, 77);
        // random phase
        free_run = 1'b1;
        for (int i = 0; i < 40000; i++) begin
            if ($urandom % 500 == 0) center = $urandom % 2;
            if ($urandom % 16 == 0) pin = ~pin;
            if ($urandom % 20 == 0) begin
                sel = $urandom % 2; wdata = $urandom; wr = 1'b1; rd = 1'b0;
            end else begin
                wr = 1'b0;
                rd = ($urandom % 6) == 0;
                sel = $urandom % 2;
            end
            tick();
        end
        wr = 1'b0; rd = 1'b0;
        tick();
        finish_run();
    end

endmodule